// File: doc/BRIEF.md
# Periodic Tick Interrupt Core for a Time-of-Day Clock

This block is the interrupt and periodic-tick part of a time-of-day clock peripheral. It sits on a byte-wide register bus and exposes two registers. One holds interrupt flags and the mask. The other holds control bits. A prescaler counts system clock cycles and produces a hundredth-second tick. The tick is latched into a flag byte. The flags are qualified by a mask and a global enable to drive one level-sensitive interrupt line.

The flag register has two meanings at the same offset. A write loads the mask. A read returns the flags and clears them, so a handler reads the register once to both learn and acknowledge the cause. The top bit of the returned byte shows whether the interrupt line was asserted in the cycle of the read. The tick period is the parameter `CYCLES_PER_TICK`; with a 50 MHz clock, ten milliseconds is 500000 cycles.

Top module: `rtc_tick_irq`

## Requirements
- R1: Only offsets 0x10 (flags/mask) and 0x11 (control) are decoded. A selected read of any other offset returns 0x00, and a write to any other offset changes neither the mask nor the control register.
- R2: The flag byte encodes bit7 = pending (interrupt line level), bit6 day, bit5 hour, bit4 minute, bit3 second, bit2 tenth-second, bit1 hundredth-second, bit0 alarm. Only bit1 has a source in this block; the others always read 0.
- R3: A write to 0x10 loads the mask with the written byte with bit7 forced to 0. The write neither sets nor clears any flag, and software cannot set the pending bit.
- R4: A selected read of 0x10 returns the flag byte and clears every flag at the same clock edge, so the interrupt line is low in the following cycle unless a tick lands on that edge.
- R5: In the control register, bit4 is the interrupt enable and bit3 is the run bit. A read of 0x11 returns the full byte last written.
- R6: The interrupt line is high exactly when the enable bit is 1 and (flags AND mask) is non-zero. Bit7 of a 0x10 read equals the line level in the read cycle.
- R7: While run = 1 and mask bit1 = 1, flag bit1 is set once every `CYCLES_PER_TICK` cycles. With either bit at 0, no tick occurs.
- R8: Any write to 0x10 or 0x11 restarts the interval. If the write leaves run and mask bit1 both set, the next tick sets flag bit1 exactly `CYCLES_PER_TICK` clock edges after the write edge.
- R9: Reset (rst_n low, asynchronous) clears the flags, mask, control register and read data, drives the interrupt low, and halts the tick.
- R10: When a tick and a selected read of 0x10 share a clock edge, the read returns the value from before the tick and flag bit1 is set after that edge.
- R11: Read data is registered. It is updated on the edge that samples a selected read and holds its value at all other times, including across writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Bus cycle select |
| wr | input | 1 | 1 = write, 0 = read, qualified by sel |
| addr | input | ADDR_W | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
The bench counts clock edges from the write that arms the tick and samples the line one cycle before and one cycle after the expected edge. A prescaler that is off by one, or that ignores the restart from a later write, is caught at one of those two samples. A read is placed exactly on the tick edge: a design that lets the clear win drops that tick, and the following read shows 0x00 where 0x82 is expected. Further cases cover:
- running with enable off, where the flag sets but the line stays low and bit7 reads 0;
- writing 0xFF to the mask, where a design that stored bit7 or echoed the write would return the pending bit;
- a reset taken mid-run, which must leave no tick behind.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

    localparam int BYTE_W   = 8;
    localparam int FLAG_W   = 7;

    // register offsets
    localparam int OFS_FLAGS = 'h10;
    localparam int OFS_CTRL  = 'h11;

    // flag byte bit positions
    localparam int FB_PEND = 7;
    localparam int FB_HSEC = 1;

    // control byte bit positions
    localparam int CB_IEN  = 4;
    localparam int CB_RUN  = 3;

    typedef struct packed {
        logic [BYTE_W-1:0] mask;
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] rdata;
    } host_regs_t;

endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
    import rtc_tick_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_mask,
    output logic              wr_ctrl,
    output logic              rd_flags,
    output logic              rd_ctrl
);

    localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(OFS_FLAGS);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);

    logic hit_flags;
    logic hit_ctrl;

    always_comb begin
        hit_flags = (addr == A_FLAGS);
        hit_ctrl  = (addr == A_CTRL);
        wr_mask   = sel &&  wr && hit_flags;
        wr_ctrl   = sel &&  wr && hit_ctrl;
        rd_flags  = sel && !wr && hit_flags;
        rd_ctrl   = sel && !wr && hit_ctrl;
    end

endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
    parameter int CYCLES_PER_TICK = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,   // run and hundredth mask both set
    input  logic touch,    // register write: restart the interval
    output logic tick
);

    localparam int CNT_W = (CYCLES_PER_TICK > 1) ? $clog2(CYCLES_PER_TICK) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES_PER_TICK - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             at_last;

    always_comb begin
        at_last = (cnt_q == LAST);
        tick    = active && !touch && at_last;
        if (!active || touch || at_last) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
    import rtc_tick_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_vec,   // one-cycle event per flag
    input  logic              clr,       // read-clear of the flag byte
    input  logic [FLAG_W-1:0] mask,
    input  logic              ien,
    output logic [FLAG_W-1:0] flags,
    output logic              irq
);

    logic [FLAG_W-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = clr ? '0 : flags_q;
        // a new event is kept even when the clear lands on the same edge
        flags_d = flags_d | set_vec;
        irq     = ien && |(flags_q & mask);
        flags   = flags_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

endmodule

// File: rtl/rtc_tick_irq.sv
module rtc_tick_irq
    import rtc_tick_pkg::*;
#(
    parameter int ADDR_W          = 5,
    parameter int CYCLES_PER_TICK = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              irq
);

    logic wr_mask, wr_ctrl, rd_flags, rd_ctrl;
    logic touch, active, tick;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] flags_q;
    logic [BYTE_W-1:0] mask_q, ctrl_q;

    host_regs_t st_d, st_q;

    rtc_bus_decode #(.ADDR_W(ADDR_W)) i_dec (
        .sel      (sel),
        .wr       (wr),
        .addr     (addr),
        .wr_mask  (wr_mask),
        .wr_ctrl  (wr_ctrl),
        .rd_flags (rd_flags),
        .rd_ctrl  (rd_ctrl)
    );

    always_comb begin
        mask_q  = st_q.mask;
        ctrl_q  = st_q.ctrl;
        touch   = wr_mask || wr_ctrl;
        active  = st_q.ctrl[CB_RUN] && st_q.mask[FB_HSEC];
        set_vec = '0;
        set_vec[FB_HSEC] = tick;
    end

    rtc_tick_gen #(.CYCLES_PER_TICK(CYCLES_PER_TICK)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .touch  (touch),
        .tick   (tick)
    );

    rtc_irq_status i_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr     (rd_flags),
        .mask    (st_q.mask[FLAG_W-1:0]),
        .ien     (st_q.ctrl[CB_IEN]),
        .flags   (flags_q),
        .irq     (irq)
    );

    always_comb begin
        st_d = st_q;
        if (wr_mask) begin
            st_d.mask = {1'b0, wdata[FLAG_W-1:0]};
        end
        if (wr_ctrl) begin
            st_d.ctrl = wdata;
        end
        if (sel && !wr) begin
            if (rd_flags) begin
                st_d.rdata = {irq, flags_q};
            end else if (rd_ctrl) begin
                st_d.rdata = st_q.ctrl;
            end else begin
                st_d.rdata = '0;
            end
        end
        rdata = st_q.rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rtc_tick_irq_chk.sv
module rtc_tick_irq_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input logic              irq,
    input logic [7:0]        mask_q,
    input logic [7:0]        ctrl_q,
    input logic [6:0]        flags_q,
    input logic              tick
);

    logic rd_f, rd_any, wr_f, wr_other;

    always_comb begin
        rd_f     = sel && !wr && (addr == ADDR_W'('h10));
        rd_any   = sel && !wr;
        wr_f     = sel &&  wr && (addr == ADDR_W'('h10));
        wr_other = sel &&  wr && (addr != ADDR_W'('h10)) && (addr != ADDR_W'('h11));
    end

    // R1
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_other |=> ($stable(mask_q) && $stable(ctrl_q)));

    // R3
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_f |=> (mask_q == {1'b0, $past(wdata[6:0])}));

    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_f && !tick) |=> (flags_q == 7'd0 && !irq));

    // R6
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_q[4]);

    // R6
    pending_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_f |=> (rdata[7] == $past(irq)));

    // R7
    tick_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[1]) |-> $past(ctrl_q[3] && mask_q[1]));

    // R10
    tick_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_f && tick) |=> flags_q[1]);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> $stable(rdata));

endmodule

bind rtc_tick_irq rtc_tick_irq_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .wr      (wr),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq     (irq),
    .mask_q  (mask_q),
    .ctrl_q  (ctrl_q),
    .flags_q (flags_q),
    .tick    (tick)
);

// File: tb/test_rtc_tick_irq.sv
module test_rtc_tick_irq;

    localparam int AW = 5;
    localparam int N  = 50;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } exp_t;

    exp_t sb[$];
    event rd_done;

    always #10 clk = ~clk;   // 50 MHz

    rtc_tick_irq #(.ADDR_W(AW), .CYCLES_PER_TICK(N)) i_rtc_tick_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .wr    (wr),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp,
                         input string req, input string what);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    // Driver: queue the expectation, run the read; monitor compares.
    task automatic bus_read(input logic [AW-1:0] a, input logic [7:0] exp,
                            input string req);
        exp_t e;
        e.exp = exp;
        e.req = req;
        sb.push_back(e);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
        -> rd_done;
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor
    initial begin
        forever begin
            @(rd_done);
            if (sb.size() == 0) begin
                vectors++;
                errors++;
                $display("FAIL R11 monitor: actual read with empty queue, expected none");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rdata, e.exp, e.req, "read data");
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog: actual hung run, expected completion");
        finish_run();
    end

    initial begin
        // R9 reset state
        idle(3);
        check(rdata, 8'h00, "R9", "rdata in reset");
        check({7'd0, irq}, 8'h00, "R9", "irq in reset");
        rst_n = 1'b1;
        idle(1);
        bus_read(5'h10, 8'h00, "R9");
        bus_read(5'h11, 8'h00, "R9");

        // R5 control readback, R1 unmapped, R11 hold
        bus_write(5'h11, 8'hA5);
        @(negedge clk);
        bus_read(5'h11, 8'hA5, "R5");
        bus_write(5'h05, 8'hFF);
        bus_write(5'h12, 8'hFF);
        check(rdata, 8'hA5, "R11", "rdata held across writes");
        bus_read(5'h05, 8'h00, "R1");
        bus_read(5'h11, 8'hA5, "R1");
        bus_read(5'h10, 8'h00, "R1");

        // R7/R8/R6 main tick path
        bus_write(5'h11, 8'h18);
        bus_write(5'h10, 8'h02);        // arming write edge E0
        idle(N - 1);
        check({7'd0, irq}, 8'h00, "R8", "irq one edge before tick");
        idle(1);
        check({7'd0, irq}, 8'h01, "R7", "irq after first tick");
        bus_read(5'h10, 8'h82, "R2");   // bit7 pending, bit1 hundredth
        check({7'd0, irq}, 8'h00, "R4", "irq after read-clear");
        idle(N - 2);
        check({7'd0, irq}, 8'h00, "R7", "irq before second tick");
        idle(1);
        check({7'd0, irq}, 8'h01, "R7", "irq at second tick");
        bus_read(5'h10, 8'h82, "R4");

        // R8 restart from a later control write
        idle(20);
        bus_write(5'h11, 8'h18);
        idle(N - 1);
        check({7'd0, irq}, 8'h00, "R8", "no tick before restarted interval");
        idle(1);
        check({7'd0, irq}, 8'h01, "R8", "tick after restarted interval");
        bus_read(5'h10, 8'h82, "R8");

        // R10 tick and read-clear on the same edge
        bus_write(5'h10, 8'h02);
        idle(N - 1);
        bus_read(5'h10, 8'h00, "R10");  // sampled on the tick edge
        check({7'd0, irq}, 8'h01, "R10", "flag survives same-edge clear");
        bus_read(5'h10, 8'h82, "R10");

        // R6 enable off: flag sets, line stays low
        bus_write(5'h11, 8'h08);
        idle(N + 2);
        check({7'd0, irq}, 8'h00, "R6", "irq with enable off");
        bus_read(5'h10, 8'h02, "R6");

        // R7 run off, then hundredth mask off
        bus_write(5'h11, 8'h10);
        bus_read(5'h10, 8'h00, "R7");
        idle(3 * N);
        check({7'd0, irq}, 8'h00, "R7", "irq with run off");
        bus_read(5'h10, 8'h00, "R7");
        bus_write(5'h11, 8'h18);
        bus_write(5'h10, 8'h7D);
        idle(3 * N);
        check({7'd0, irq}, 8'h00, "R7", "irq with mask bit1 off");
        bus_read(5'h10, 8'h00, "R7");

        // R3 mask write cannot set pending or flags
        bus_write(5'h10, 8'hFF);
        bus_read(5'h10, 8'h00, "R3");
        idle(N);
        check({7'd0, irq}, 8'h01, "R3", "mask 0x7F still ticks");
        bus_read(5'h10, 8'h82, "R3");

        // R9 reset mid-run
        idle(N + 2);
        check({7'd0, irq}, 8'h01, "R9", "irq before reset");
        rst_n = 1'b0;
        #1;
        check({7'd0, irq}, 8'h00, "R9", "irq during reset");
        check(rdata, 8'h00, "R9", "rdata during reset");
        idle(2);
        rst_n = 1'b1;
        idle(2 * N);
        check({7'd0, irq}, 8'h00, "R9", "no tick after reset");
        bus_read(5'h10, 8'h00, "R9");
        bus_read(5'h11, 8'h00, "R9");

        idle(2);
        if (sb.size() != 0) begin
            vectors++;
            errors++;
            $display("FAIL R11 scoreboard: actual %0d left, expected 0", sb.size());
        end
        finish_run();
    end

endmodule